// File: doc/BRIEF.md
# Presettable Binary/Decade Up/Down Counter

A four-bit synchronous counter stage whose modulus is chosen while it runs: plain binary (sixteen states) or one decimal digit (ten states). It counts up or down one step per rising clock edge. A level-sensitive parallel load copies a four-bit value onto the count whenever it is asserted, with or without a clock, so the stage can be preset or cleared at any moment.

An active-low carry input acts as the count enable. An active-low carry output flags the terminal state for the current direction and modulus. It is formed combinationally from the count and the controls, so the carry output of one stage can drive the carry input of the next, and every stage of a multi-digit counter updates on the same clock edge.

Top module: `updown_counter4`

## Requirements
- R1: While preset_en is 1, q equals jam and follows every change on jam with no clock edge. jam = 4'b0000 therefore clears the count.
- R2: The count changes by exactly one step on a rising clk edge only when carry_in_n = 0 and preset_en = 0. The first rising edge at which preset_en is 0 after a preset already counts, starting from the loaded value.
- R3: When carry_in_n = 1, q holds its value across rising clk edges.
- R4: With bin_dec = 1 (binary), counting up goes from 15 to 0 and counting down goes from 0 to 15.
- R5: With bin_dec = 0 (decade), counting up goes from 9 to 0 and counting down goes from 0 to 9.
- R6: up_dn = 1 makes the count step up by one. up_dn = 0 makes it step down by one.
- R7: carry_out_n is 0 exactly when carry_in_n = 0 and either up_dn = 1 with q at the top value (15 binary, 9 decade), or up_dn = 0 with q = 0. Otherwise it is 1. It responds to its inputs without waiting for a clock edge.
- R8: In decade mode, a loaded value from 10 to 15 counts up in binary steps (15 goes to 0) and counts down by one. carry_out_n stays 1 while q holds such a value.
- R9: Two stages with the carry_out_n of the low stage wired to the carry_in_n of the high stage count through 00 to 99 in decade mode and through 0 to 255 in binary mode, in both directions, wrapping at each end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge active |
| carry_in_n | input | 1 | Active-low count enable and carry from the previous stage |
| bin_dec | input | 1 | 1 selects binary counting, 0 selects decade counting |
| up_dn | input | 1 | 1 selects counting up, 0 selects counting down |
| preset_en | input | 1 | Level-sensitive parallel load, active high |
| jam | input | 4 | Value to load while preset_en is 1 |
| q | output | 4 | Current count |
| carry_out_n | output | 1 | Active-low terminal-count flag for the next stage |

## Verification
Every state bit is visible on q, so a wrong next-state value shows on the edge right after it happens. A wrong wrap point shows the first time the counter crosses its terminal state in the selected modulus and direction. A fault in the terminal decode shows first on carry_out_n, in the same cycle, before any edge. In the two-stage chain the same fault appears one edge later as a high digit that fails to step, steps twice, or steps at the wrong moment. Stepping through the whole 00 to 99 and 0 to 255 ranges in both directions therefore exposes every boundary within one pass.

// File: rtl/updown_counter4.sv
module updown_counter4 (
  input  logic       clk,
  input  logic       carry_in_n,
  input  logic       bin_dec,
  input  logic       up_dn,
  input  logic       preset_en,
  input  logic [3:0] jam,
  output logic [3:0] q,
  output logic       carry_out_n
);

  logic [3:0] cnt;
  logic [3:0] nxt;
  logic [3:0] top;
  logic       at_end;

  assign top = bin_dec ? 4'd15 : 4'd9;

  always_comb begin
    if (up_dn) nxt = (cnt == top)   ? 4'd0 : 4'(cnt + 4'd1);
    else       nxt = (cnt == 4'd0)  ? top  : 4'(cnt - 4'd1);
  end

  always_ff @(posedge clk or posedge preset_en) begin
    if (preset_en)        cnt <= jam;
    else if (!carry_in_n) cnt <= nxt;
  end

  assign q           = preset_en ? jam : cnt;
  assign at_end      = up_dn ? (q == top) : (q == 4'd0);
  assign carry_out_n = ~(~carry_in_n & at_end);

endmodule

module updown_counter4_chk (
  input logic       clk,
  input logic       carry_in_n,
  input logic       bin_dec,
  input logic       up_dn,
  input logic       preset_en,
  input logic [3:0] jam,
  input logic [3:0] q,
  input logic       carry_out_n
);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (preset_en)
    carry_in_n |=> $stable(q));

  // R4
  bin_up_chk: assert property (@(posedge clk) disable iff (preset_en)
    (!carry_in_n && up_dn && bin_dec) |=> q == 4'($past(q) + 4'd1));

  // R6
  bin_dn_chk: assert property (@(posedge clk) disable iff (preset_en)
    (!carry_in_n && !up_dn && bin_dec) |=> q == 4'($past(q) - 4'd1));

  // R5
  dec_wrap_up_chk: assert property (@(posedge clk) disable iff (preset_en)
    (!carry_in_n && up_dn && !bin_dec && q == 4'd9) |=> q == 4'd0);

  // R5
  dec_wrap_dn_chk: assert property (@(posedge clk) disable iff (preset_en)
    (!carry_in_n && !up_dn && !bin_dec && q == 4'd0) |=> q == 4'd9);

  // R8
  illegal_co_chk: assert property (@(posedge clk) disable iff (preset_en)
    (!bin_dec && q > 4'd9) |-> carry_out_n);

  // R7
  co_gate_chk: assert property (@(posedge clk) disable iff (preset_en)
    !carry_out_n |-> !carry_in_n);

  // R1
  jam_unused_chk: assert property (@(posedge clk) disable iff (preset_en)
    !$stable(jam) |-> $stable(q) || !carry_in_n);

endmodule

bind updown_counter4 updown_counter4_chk u_chk (
  .clk(clk), .carry_in_n(carry_in_n), .bin_dec(bin_dec), .up_dn(up_dn),
  .preset_en(preset_en), .jam(jam), .q(q), .carry_out_n(carry_out_n)
);

// File: tb/test_updown_counter4.sv
module test_updown_counter4;

  logic       clk = 1'b0;
  logic       cin_n = 1'b0;
  logic       bin_dec = 1'b1;
  logic       up_dn = 1'b1;
  logic       preset_en = 1'b1;
  logic [3:0] jam_lo = 4'd0;
  logic [3:0] jam_hi = 4'd0;
  logic [3:0] q_lo, q_hi;
  logic       co_lo_n, co_hi_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  updown_counter4 i_updown_counter4 (
    .clk(clk), .carry_in_n(cin_n), .bin_dec(bin_dec), .up_dn(up_dn),
    .preset_en(preset_en), .jam(jam_lo), .q(q_lo), .carry_out_n(co_lo_n)
  );

  updown_counter4 i_updown_counter4_hi (
    .clk(clk), .carry_in_n(co_lo_n), .bin_dec(bin_dec), .up_dn(up_dn),
    .preset_en(preset_en), .jam(jam_hi), .q(q_hi), .carry_out_n(co_hi_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [3:0] lo, input logic [3:0] hi);
    preset_en = 1'b1;
    jam_lo = lo;
    jam_hi = hi;
    tick();
    preset_en = 1'b0;
  endtask

  task automatic t_preset();
    @(negedge clk);
    preset_en = 1'b1;
    jam_lo = 4'd10;
    #2;
    chk("R1 async load", q_lo, 10);
    jam_lo = 4'd0;
    #2;
    chk("R1 clear by jam zero", q_lo, 0);
    jam_lo = 4'd6;
    tick();
    chk("R1 held across edge", q_lo, 6);
  endtask

  task automatic t_release();
    bin_dec = 1'b1; up_dn = 1'b1; cin_n = 1'b0;
    load(4'd5, 4'd0);
    chk("R2 value after release", q_lo, 5);
    tick();
    chk("R2 first edge counts", q_lo, 6);
    tick();
    chk("R6 up step", q_lo, 7);
  endtask

  task automatic t_inhibit();
    bin_dec = 1'b1; up_dn = 1'b1;
    load(4'd15, 4'd0);
    cin_n = 1'b1;
    #1;
    chk("R7 co high when carry in high", co_lo_n, 1);
    tick(); tick(); tick();
    chk("R3 held with carry in high", q_lo, 15);
    cin_n = 1'b0;
    #1;
    chk("R7 co low at 15 up without clock", co_lo_n, 0);
  endtask

  task automatic t_binary();
    bin_dec = 1'b1; up_dn = 1'b1; cin_n = 1'b0;
    load(4'd14, 4'd0);
    chk("R7 co high below top", co_lo_n, 1);
    tick();
    chk("R4 14 to 15", q_lo, 15);
    tick();
    chk("R4 up wrap 15 to 0", q_lo, 0);
    up_dn = 1'b0;
    #1;
    chk("R7 co low at 0 down", co_lo_n, 0);
    tick();
    chk("R4 down wrap 0 to 15", q_lo, 15);
    tick();
    chk("R6 down step", q_lo, 14);
  endtask

  task automatic t_decade();
    bin_dec = 1'b0; up_dn = 1'b1; cin_n = 1'b0;
    load(4'd8, 4'd0);
    tick();
    chk("R5 8 to 9", q_lo, 9);
    chk("R7 co low at 9 decade up", co_lo_n, 0);
    tick();
    chk("R5 up wrap 9 to 0", q_lo, 0);
    up_dn = 1'b0;
    load(4'd1, 4'd0);
    tick();
    chk("R5 1 to 0", q_lo, 0);
    chk("R7 co low at 0 decade down", co_lo_n, 0);
    tick();
    chk("R5 down wrap 0 to 9", q_lo, 9);
  endtask

  task automatic t_illegal();
    bin_dec = 1'b0; up_dn = 1'b1; cin_n = 1'b0;
    load(4'd12, 4'd0);
    chk("R8 co high at 12 up", co_lo_n, 1);
    tick(); chk("R8 12 to 13", q_lo, 13);
    tick(); chk("R8 13 to 14", q_lo, 14);
    tick(); chk("R8 14 to 15", q_lo, 15);
    chk("R8 co high at 15", co_lo_n, 1);
    tick(); chk("R8 15 to 0", q_lo, 0);
    up_dn = 1'b0;
    load(4'd12, 4'd0);
    chk("R8 co high at 12 down", co_lo_n, 1);
    tick(); chk("R8 12 down to 11", q_lo, 11);
  endtask

  task automatic t_chain(input logic bin, input logic up);
    int span = bin ? 256 : 100;
    int v = up ? 0 : span - 1;
    int hi_exp, lo_exp;
    int bad = 0;
    bin_dec = bin; up_dn = up; cin_n = 1'b0;
    if (bin) load(4'(v % 16), 4'(v / 16));
    else     load(4'(v % 10), 4'(v / 10));
    for (int i = 0; i < span + 3; i++) begin
      tick();
      v = up ? (v + 1) % span : (v + span - 1) % span;
      hi_exp = bin ? v / 16 : v / 10;
      lo_exp = bin ? v % 16 : v % 10;
      if (q_hi != hi_exp || q_lo != lo_exp) begin
        bad++;
        chk("R9 chain value", {q_hi, q_lo}, (hi_exp << 4) | lo_exp);
      end
      if (bad == 0 && v == (up ? span - 1 : 0))
        chk("R9 chain terminal carry", co_hi_n, 0);
    end
    chk("R9 chain mismatches", bad, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick();
    chk("R1 initial preset value", q_lo, 0);
    t_preset();
    t_release();
    t_inhibit();
    t_binary();
    t_decade();
    t_illegal();
    t_chain(1'b0, 1'b1);
    t_chain(1'b0, 1'b0);
    t_chain(1'b1, 1'b1);
    t_chain(1'b1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule